// File: doc/BRIEF.md
# Display Link Training Sequencer

This block brings up a display link by walking a sink through the usual two training phases. On `start_i` it latches the requested link rate, the lane count and what the sink reports about itself. It then writes the rate and the lane count to the sink. Next it selects training pattern 1 and runs clock recovery. When that succeeds it selects pattern 2 and runs channel equalisation. It ends every attempt by turning the pattern off. Between status polls it reads the sink's adjust requests, merges them into one drive setting shared by all active lanes, and commits that setting to the sink. The per-lane drive bytes are also driven out on `drive_level_o`.

All sink traffic goes through a simple register-access port. A request is held with address, direction and write data until the responder pulses `bus_done_i`. On a read, the responder returns data in the same cycle as the done pulse. The supported maximum swing and the per-swing pre-emphasis limits are inputs. If an attempt at a higher rate fails, the sequence restarts once at the lowest rate (`LOW_RATE`). The outcome is reported with a one-cycle `done_o`, the `trained_o` and `failed_o` flags and `final_rate_o`.

Top module: `lt_seq`

## Requirements
- R1: An attempt begins with a write of the rate to address 0x00, then a write of the lane count to address 0x01. In that lane-count write, bits 2:0 hold the count (1, 2 or 4) and bit 7 is set only when the sink revision is 0x11 or higher and the sink reports enhanced framing.
- R2: After the lane count, pattern 1 is written to address 0x02 (pattern code in bits 1:0). It is followed by a write of drive word zero to address 0x03.
- R3: A status read from address 0x04 returns one 4-bit nibble per lane, lane i in bits 4i+3:4i. Nibble bit 0 means clock recovery done, bit 1 means equalised and bit 2 means symbol lock. Bit 16 means inter-lane alignment. Lanes at or above the lane count are ignored.
- R4: Clock recovery passes as soon as a status read shows bit 0 set on every active lane. Pattern 2 is written only after clock recovery has passed.
- R5: Clock recovery fails after 5 status reads at the same swing. The try count restarts whenever the committed swing differs from the one seen at the previous status read.
- R6: Clock recovery stops at once when a status read fails while the committed drive carries the swing-maximum flag.
- R7: An adjust read from address 0x06 holds one nibble per lane (swing in bits 1:0, pre-emphasis in bits 3:2). The block takes the highest swing and the highest pre-emphasis over the active lanes only. The drive byte is {2'b0, pre_max, pre[1:0], sw_max, sw[1:0]}. It is written as byte i of the address 0x03 word for each active lane, and inactive lanes get zero.
- R8: Swing is clamped to `max_swing_i` and `sw_max` is set when the request reaches it. Pre-emphasis is then clamped to `pre_limit_i[2s+1:2s]` for the final swing s, and `pre_max` is set when the request reaches that limit.
- R9: Equalisation passes when alignment is set and every active lane has bits 0, 1 and 2 set. It stops as failed when an active lane loses bit 0, or after 6 status reads.
- R10: Every attempt ends with a write of pattern 0, and `done_o` follows only that write. An attempt whose clock recovery failed skips equalisation.
- R11: If an attempt fails at a rate other than `LOW_RATE`, the whole sequence restarts once at `LOW_RATE`. `done_o` is a single-cycle pulse, exactly one of `trained_o` and `failed_o` is set with it, and a failure always reports `LOW_RATE`.
- R12: A request holds its address, direction and write data steady until `bus_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin training (ignored while busy) |
| rate_i | input | 8 | Requested link rate code |
| lanes_i | input | 3 | Active lane count: 1, 2 or 4 |
| sink_rev_i | input | 8 | Sink capability revision |
| sink_ef_i | input | 1 | Sink supports enhanced framing |
| max_swing_i | input | 2 | Highest supported swing level |
| pre_limit_i | input | 8 | Pre-emphasis limit per swing, 2 bits each |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | Sink register address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with done |
| bus_done_i | input | 1 | Access complete |
| drive_level_o | output | 32 | Per-lane drive bytes, lane i in byte i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trained_o | output | 1 | Last sequence succeeded |
| failed_o | output | 1 | Last sequence failed |
| final_rate_o | output | 8 | Rate of the last attempt |

## Verification
The hardest condition to reach is the clock-recovery try count restarting on a swing change. That needs a sink whose adjust requests change the swing once and then hold it, while the status reads keep failing. The bench's sink model has three adjust modes for this. A fixed request gives 5 status reads. A request stuck one step above zero gives 6, because of the restart. A rising ramp hits the swing ceiling and stops after 4 reads. The rate fallback is reached with a sink that fails every attempt at a rate other than the lowest one. The merge and clamp logic is swept over all sixteen nibble values of one lane, with the inactive lanes loaded with requests that must be ignored.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int LANE_MAX = 4;
    localparam int NIB_W    = 4;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = LANE_MAX * BYTE_W;
    localparam int ADDR_W   = 8;
    localparam int LVL_W    = 2;
    localparam int CNT_W    = 3;
    localparam int RATE_W   = 8;
    localparam int PAT_W    = 2;

    localparam int CR_TRY_LIMIT = 5;
    localparam int EQ_TRY_LIMIT = 6;

    localparam logic [ADDR_W-1:0] A_RATE    = 8'h00;
    localparam logic [ADDR_W-1:0] A_LANES   = 8'h01;
    localparam logic [ADDR_W-1:0] A_PATTERN = 8'h02;
    localparam logic [ADDR_W-1:0] A_DRIVE   = 8'h03;
    localparam logic [ADDR_W-1:0] A_STATUS  = 8'h04;
    localparam logic [ADDR_W-1:0] A_ADJUST  = 8'h06;

    localparam int NB_CR   = 0;
    localparam int NB_EQ   = 1;
    localparam int NB_LOCK = 2;
    localparam int EF_BIT  = 7;
    localparam logic [7:0] EF_MIN_REV = 8'h11;

    localparam logic [PAT_W-1:0] PAT_OFF = 2'd0;
    localparam logic [PAT_W-1:0] PAT_CR  = 2'd1;
    localparam logic [PAT_W-1:0] PAT_EQ  = 2'd2;

    typedef struct packed {
        logic             pre_max;
        logic [LVL_W-1:0] pre;
        logic             sw_max;
        logic [LVL_W-1:0] sw;
    } drive_t;

    typedef enum logic [3:0] {
        S_IDLE, S_RATE, S_LANES, S_PAT1, S_DRV_CR, S_ST_CR, S_ADJ_CR,
        S_PAT2, S_ST_EQ, S_ADJ_EQ, S_DRV_EQ, S_PAT0
    } lt_state_t;

    function automatic logic [LANE_MAX-1:0] lane_mask(input logic [CNT_W-1:0] n);
        logic [LANE_MAX:0] t;
        t = ({{LANE_MAX{1'b0}}, 1'b1} << n) - 1'b1;
        return t[LANE_MAX-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] drive_byte(input drive_t d);
        return {{(BYTE_W-$bits(drive_t)){1'b0}}, d};
    endfunction
endpackage

// File: rtl/lt_status_eval.sv
module lt_status_eval
    import lt_pkg::*;
(
    input  logic [LANE_MAX*NIB_W:0] status_i,
    input  logic [LANE_MAX-1:0]     mask_i,
    output logic                    cr_all_o,
    output logic                    eq_all_o
);
    logic [LANE_MAX-1:0] lane_cr;
    logic [LANE_MAX-1:0] lane_eq;
    logic                unused_nib_top;

    for (genvar g = 0; g < LANE_MAX; g++) begin : g_lane
        assign lane_cr[g] = !mask_i[g] || status_i[g*NIB_W + NB_CR];
        assign lane_eq[g] = !mask_i[g] ||
                            (status_i[g*NIB_W + NB_CR] &&
                             status_i[g*NIB_W + NB_EQ] &&
                             status_i[g*NIB_W + NB_LOCK]);
    end

    always_comb begin
        unused_nib_top = 1'b0;
        for (int i = 0; i < LANE_MAX; i++)
            unused_nib_top = unused_nib_top ^ status_i[i*NIB_W + NIB_W - 1];
    end

    assign cr_all_o = &lane_cr;
    assign eq_all_o = (&lane_eq) && status_i[LANE_MAX*NIB_W];
endmodule

// File: rtl/lt_adjust.sv
module lt_adjust
    import lt_pkg::*;
(
    input  logic [LANE_MAX*NIB_W-1:0]       req_i,
    input  logic [LANE_MAX-1:0]             mask_i,
    input  logic [LVL_W-1:0]                max_sw_i,
    input  logic [(1<<LVL_W)*LVL_W-1:0]     pre_lim_i,
    output drive_t                          drv_o
);
    logic [LVL_W-1:0] lane_sw  [LANE_MAX];
    logic [LVL_W-1:0] lane_pre [LANE_MAX];
    logic [LVL_W-1:0] sw_hi, pre_hi, pre_cap;

    for (genvar g = 0; g < LANE_MAX; g++) begin : g_lane
        assign lane_sw[g]  = mask_i[g] ? req_i[g*NIB_W +: LVL_W] : '0;
        assign lane_pre[g] = mask_i[g] ? req_i[g*NIB_W + LVL_W +: LVL_W] : '0;
    end

    always_comb begin
        sw_hi  = '0;
        pre_hi = '0;
        for (int i = 0; i < LANE_MAX; i++) begin
            if (lane_sw[i]  > sw_hi)  sw_hi  = lane_sw[i];
            if (lane_pre[i] > pre_hi) pre_hi = lane_pre[i];
        end
        drv_o = '0;
        if (sw_hi >= max_sw_i) begin
            drv_o.sw     = max_sw_i;
            drv_o.sw_max = 1'b1;
        end else begin
            drv_o.sw     = sw_hi;
        end
        pre_cap = pre_lim_i[drv_o.sw*LVL_W +: LVL_W];
        if (pre_hi >= pre_cap) begin
            drv_o.pre     = pre_cap;
            drv_o.pre_max = 1'b1;
        end else begin
            drv_o.pre     = pre_hi;
        end
    end
endmodule

// File: rtl/lt_seq.sv
module lt_seq
    import lt_pkg::*;
#(
    parameter logic [RATE_W-1:0] LOW_RATE = 8'h06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CNT_W-1:0]  lanes_i,
    input  logic [7:0]        sink_rev_i,
    input  logic              sink_ef_i,
    input  logic [LVL_W-1:0]  max_swing_i,
    input  logic [7:0]        pre_limit_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [WORD_W-1:0] bus_wdata_o,
    input  logic [WORD_W-1:0] bus_rdata_i,
    input  logic              bus_done_i,
    output logic [WORD_W-1:0] drive_level_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              trained_o,
    output logic              failed_o,
    output logic [RATE_W-1:0] final_rate_o
);
    lt_state_t           state_q;
    logic [RATE_W-1:0]   rate_q;
    logic [CNT_W-1:0]    lanes_q;
    logic [LANE_MAX-1:0] mask_q;
    logic                ef_q;
    drive_t              drv_q;
    logic                cr_ok_q, eq_ok_q;
    logic [CNT_W-1:0]    tries_q;
    logic                sw_seen_q;
    logic [LVL_W-1:0]    last_sw_q;
    logic                done_q, trained_q, failed_q;

    logic                st_cr_all, st_eq_all;
    drive_t              adj_drv;
    logic [WORD_W-1:0]   drive_word;
    logic [CNT_W-1:0]    cr_tries_nxt;
    logic                unused_rd_hi;

    assign unused_rd_hi = ^bus_rdata_i[WORD_W-1:LANE_MAX*NIB_W+1];

    lt_status_eval u_eval (
        .status_i (bus_rdata_i[LANE_MAX*NIB_W:0]),
        .mask_i   (mask_q),
        .cr_all_o (st_cr_all),
        .eq_all_o (st_eq_all)
    );

    lt_adjust u_adj (
        .req_i     (bus_rdata_i[LANE_MAX*NIB_W-1:0]),
        .mask_i    (mask_q),
        .max_sw_i  (max_swing_i),
        .pre_lim_i (pre_limit_i),
        .drv_o     (adj_drv)
    );

    for (genvar g = 0; g < LANE_MAX; g++) begin : g_drv
        assign drive_word[g*BYTE_W +: BYTE_W] = mask_q[g] ? drive_byte(drv_q) : '0;
    end

    assign cr_tries_nxt = (sw_seen_q && last_sw_q == drv_q.sw) ? tries_q + 1'b1 : CNT_W'(1);

    always_comb begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = A_RATE;
        bus_wdata_o = '0;
        case (state_q)
            S_RATE:   bus_wdata_o[RATE_W-1:0] = rate_q;
            S_LANES: begin
                bus_addr_o                 = A_LANES;
                bus_wdata_o[CNT_W-1:0]     = lanes_q;
                bus_wdata_o[EF_BIT]        = ef_q;
            end
            S_PAT1: begin bus_addr_o = A_PATTERN; bus_wdata_o[PAT_W-1:0] = PAT_CR;  end
            S_PAT2: begin bus_addr_o = A_PATTERN; bus_wdata_o[PAT_W-1:0] = PAT_EQ;  end
            S_PAT0: begin bus_addr_o = A_PATTERN; bus_wdata_o[PAT_W-1:0] = PAT_OFF; end
            S_DRV_CR, S_DRV_EQ: begin bus_addr_o = A_DRIVE; bus_wdata_o = drive_word; end
            S_ST_CR, S_ST_EQ:   begin bus_we_o = 1'b0; bus_addr_o = A_STATUS; end
            S_ADJ_CR, S_ADJ_EQ: begin bus_we_o = 1'b0; bus_addr_o = A_ADJUST; end
            default: begin bus_req_o = 1'b0; bus_we_o = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            rate_q    <= '0;
            lanes_q   <= '0;
            mask_q    <= '0;
            ef_q      <= 1'b0;
            drv_q     <= '0;
            cr_ok_q   <= 1'b0;
            eq_ok_q   <= 1'b0;
            tries_q   <= '0;
            sw_seen_q <= 1'b0;
            last_sw_q <= '0;
            done_q    <= 1'b0;
            trained_q <= 1'b0;
            failed_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == S_IDLE) begin
                if (start_i) begin
                    rate_q    <= rate_i;
                    lanes_q   <= lanes_i;
                    mask_q    <= lane_mask(lanes_i);
                    ef_q      <= sink_ef_i && (sink_rev_i >= EF_MIN_REV);
                    trained_q <= 1'b0;
                    failed_q  <= 1'b0;
                    drv_q     <= '0;
                    cr_ok_q   <= 1'b0;
                    eq_ok_q   <= 1'b0;
                    tries_q   <= '0;
                    sw_seen_q <= 1'b0;
                    state_q   <= S_RATE;
                end
            end else if (bus_done_i) begin
                case (state_q)
                    S_RATE:   state_q <= S_LANES;
                    S_LANES:  state_q <= S_PAT1;
                    S_PAT1:   state_q <= S_DRV_CR;
                    S_DRV_CR: state_q <= S_ST_CR;
                    S_ST_CR: begin
                        tries_q   <= cr_tries_nxt;
                        sw_seen_q <= 1'b1;
                        last_sw_q <= drv_q.sw;
                        if (st_cr_all) begin
                            cr_ok_q <= 1'b1;
                            tries_q <= '0;
                            state_q <= S_PAT2;
                        end else if (drv_q.sw_max || cr_tries_nxt == CNT_W'(CR_TRY_LIMIT)) begin
                            state_q <= S_PAT0;
                        end else begin
                            state_q <= S_ADJ_CR;
                        end
                    end
                    S_ADJ_CR: begin drv_q <= adj_drv; state_q <= S_DRV_CR; end
                    S_PAT2:   state_q <= S_ST_EQ;
                    S_ST_EQ: begin
                        if (st_eq_all) begin
                            eq_ok_q <= 1'b1;
                            state_q <= S_PAT0;
                        end else if (!st_cr_all) begin
                            cr_ok_q <= 1'b0;
                            state_q <= S_PAT0;
                        end else if (tries_q + 1'b1 == CNT_W'(EQ_TRY_LIMIT)) begin
                            state_q <= S_PAT0;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            state_q <= S_ADJ_EQ;
                        end
                    end
                    S_ADJ_EQ: begin drv_q <= adj_drv; state_q <= S_DRV_EQ; end
                    S_DRV_EQ: state_q <= S_ST_EQ;
                    S_PAT0: begin
                        if (!(cr_ok_q && eq_ok_q) && rate_q != LOW_RATE) begin
                            rate_q    <= LOW_RATE;
                            drv_q     <= '0;
                            cr_ok_q   <= 1'b0;
                            eq_ok_q   <= 1'b0;
                            tries_q   <= '0;
                            sw_seen_q <= 1'b0;
                            state_q   <= S_RATE;
                        end else begin
                            done_q    <= 1'b1;
                            trained_q <= cr_ok_q && eq_ok_q;
                            failed_q  <= !(cr_ok_q && eq_ok_q);
                            state_q   <= S_IDLE;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign drive_level_o = drive_word;
    assign busy_o        = (state_q != S_IDLE);
    assign done_o        = done_q;
    assign trained_o     = trained_q;
    assign failed_o      = failed_q;
    assign final_rate_o  = rate_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R11
    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (trained_o != failed_o)); // R11
    AST_FAIL_LOW_RATE: assert property (@(posedge clk) disable iff (rst)
        done_o && failed_o |-> final_rate_o == LOW_RATE); // R11
    AST_SWING_CAP: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> drv_q.sw <= max_swing_i); // R8
    AST_EQ_NEEDS_CR: assert property (@(posedge clk) disable iff (rst)
        bus_req_o && bus_we_o && bus_addr_o == A_PATTERN && bus_wdata_o[PAT_W-1:0] == PAT_EQ |-> cr_ok_q); // R4
    AST_PAT0_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(state_q) == S_PAT0); // R10
endmodule

// File: tb/sim_lt_seq.sv
module sim_lt_seq;
    import lt_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam logic [7:0] LOW = 8'h06;
    localparam logic [7:0] HIGH = 8'h0A;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 1'b0;
    logic [7:0] rate_i = '0, sink_rev_i = '0, pre_limit_i = '0;
    logic [2:0] lanes_i = '0;
    logic sink_ef_i = 1'b0;
    logic [1:0] max_swing_i = '0;
    logic bus_req_o, bus_we_o, bus_done_i = 1'b0;
    logic [7:0] bus_addr_o;
    logic [31:0] bus_wdata_o, bus_rdata_i = '0, drive_level_o;
    logic busy_o, done_o, trained_o, failed_o;
    logic [7:0] final_rate_o;

    int nchk = 0, nfail = 0, cyc = 0;

    // sink model controls
    int sc_cr_at, sc_eq_at, sc_lose_at, sc_adj_mode;
    logic sc_no_align, sc_fail_high;
    logic [15:0] sc_adj_word;
    int sc_lanes;
    logic [1:0] cur_pat;
    logic [7:0] cur_rate;
    int st_cnt, adj_cnt;

    logic [7:0]  lg_addr [0:255];
    logic        lg_we   [0:255];
    logic [31:0] lg_data [0:255];
    int n_log;

    always #(CLK_PERIOD/2) clk = ~clk;

    lt_seq #(.LOW_RATE(LOW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .rate_i(rate_i), .lanes_i(lanes_i),
        .sink_rev_i(sink_rev_i), .sink_ef_i(sink_ef_i), .max_swing_i(max_swing_i),
        .pre_limit_i(pre_limit_i), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
        .bus_done_i(bus_done_i), .drive_level_o(drive_level_o), .busy_o(busy_o),
        .done_o(done_o), .trained_o(trained_o), .failed_o(failed_o),
        .final_rate_o(final_rate_o)
    );

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                nfail++;
                $display("FAIL watchdog act=%0d exp=<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
                $finish;
            end
        end
    end

    // sink responder
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req_o) begin
                logic [7:0]  a;
                logic        w;
                logic [31:0] d, r;
                a = bus_addr_o; w = bus_we_o; d = bus_wdata_o; r = '0;
                if (n_log < 256) begin
                    lg_addr[n_log] = a; lg_we[n_log] = w; lg_data[n_log] = d;
                    n_log++;
                end
                if (w) begin
                    if (a == A_PATTERN) begin cur_pat = d[1:0]; st_cnt = 0; adj_cnt = 0; end
                    if (a == A_RATE) cur_rate = d[7:0];
                end else if (a == A_STATUS) begin
                    st_cnt++;
                    for (int i = 0; i < sc_lanes; i++) begin
                        logic cr, eq;
                        if (cur_pat == 2'd1) begin
                            cr = !(sc_fail_high && cur_rate != LOW) && sc_cr_at != 0 && st_cnt >= sc_cr_at;
                            eq = 1'b0;
                        end else begin
                            cr = !(sc_lose_at != 0 && st_cnt >= sc_lose_at);
                            eq = sc_eq_at != 0 && st_cnt >= sc_eq_at;
                        end
                        r[i*4 +: 4] = {1'b0, eq, eq, cr};
                    end
                    r[16] = (cur_pat == 2'd2) && sc_eq_at != 0 && st_cnt >= sc_eq_at && !sc_no_align;
                end else if (a == A_ADJUST) begin
                    adj_cnt++;
                    if (sc_adj_mode == 1) begin
                        logic [1:0] s;
                        s = (adj_cnt >= 3) ? 2'd3 : 2'(adj_cnt);
                        r[15:0] = {4{2'b00, s}};
                    end else begin
                        r[15:0] = sc_adj_word;
                    end
                end
                repeat (LAT) @(negedge clk);
                bus_rdata_i = r;
                bus_done_i  = 1'b1;
                @(negedge clk);
                bus_done_i  = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int cnt_ops(input logic [7:0] a, input logic w);
        int c = 0;
        for (int i = 0; i < n_log; i++) if (lg_addr[i] == a && lg_we[i] == w) c++;
        return c;
    endfunction

    function automatic logic [31:0] nth_wr(input logic [7:0] a, input int k);
        int c = 0;
        for (int i = 0; i < n_log; i++)
            if (lg_addr[i] == a && lg_we[i]) begin
                if (c == k) return lg_data[i];
                c++;
            end
        return 32'hDEADBEEF;
    endfunction

    function automatic logic [7:0] exp_drv(input logic [3:0] n0);
        logic [1:0] sw, pre, lim;
        logic swf, pref;
        sw = (n0[1:0] > 2'd1) ? n0[1:0] : 2'd1;
        pre = n0[3:2];
        swf = sw >= 2'd2;
        if (swf) sw = 2'd2;
        lim = 2'd3 - sw;
        pref = pre >= lim;
        if (pref) pre = lim;
        return {2'b00, pref, pre, swf, sw};
    endfunction

    task automatic sink(input int cr_at, input int eq_at, input int lose_at, input logic no_align,
                        input logic fail_high, input int mode, input logic [15:0] word);
        sc_cr_at = cr_at; sc_eq_at = eq_at; sc_lose_at = lose_at; sc_no_align = no_align;
        sc_fail_high = fail_high; sc_adj_mode = mode; sc_adj_word = word;
    endtask

    task automatic run(input logic [7:0] rate, input logic [2:0] ln, input logic [7:0] rev,
                       input logic ef, input logic [1:0] msw, input logic [7:0] plim);
        @(negedge clk);
        rate_i = rate; lanes_i = ln; sink_rev_i = rev; sink_ef_i = ef;
        max_swing_i = msw; pre_limit_i = plim; sc_lanes = int'(ln);
        n_log = 0; cur_pat = 2'd0; cur_rate = 8'h00; st_cnt = 0; adj_cnt = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        n_log = 0; sc_lanes = 4; cur_pat = 0; cur_rate = 0; st_cnt = 0; adj_cnt = 0;
        sink(1, 1, 0, 1'b0, 1'b0, 0, 16'h0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R11 reset busy", {31'b0, busy_o}, 0);
        chk("R11 reset flags", {29'b0, done_o, trained_o, failed_o}, 0);
        chk("R12 reset req", {31'b0, bus_req_o}, 0);
        chk("R7 reset drive", drive_level_o, 0);

        // R1 lane-count byte and order, swept over revision, framing and lane count
        for (int k = 0; k < 3; k++)
            for (int e = 0; e < 2; e++)
                for (int li = 0; li < 3; li++) begin
                    logic [7:0] rv;
                    logic [2:0] ln;
                    logic [31:0] expb;
                    rv = 8'h10 + 8'(k);
                    ln = 3'(1 << li);
                    expb = {24'b0, (rv >= 8'h11 && e == 1), 4'b0, ln};
                    sink(1, 1, 0, 1'b0, 1'b0, 0, 16'h0);
                    run(HIGH, ln, rv, e[0], 2'd3, 8'hFF);
                    chk("R1 lane count byte", nth_wr(A_LANES, 0), expb);
                    chk("R1 order rate then lanes",
                        {16'b0, lg_addr[0], lg_addr[1]}, {16'b0, A_RATE, A_LANES});
                    chk("R9 quick pass trained", {31'b0, trained_o}, 1);
                end

        // R2 / R4 / R10 single quick pass, detailed log
        sink(1, 1, 0, 1'b0, 1'b0, 0, 16'h0);
        run(HIGH, 3'd4, 8'h12, 1'b1, 2'd3, 8'hFF);
        chk("R1 rate value", lg_data[0], {24'b0, HIGH});
        chk("R2 pattern1 write", {lg_addr[2], lg_data[2][23:0]}, {A_PATTERN, 24'd1});
        chk("R2 zero drive write", {lg_addr[3], lg_data[3][23:0]}, {A_DRIVE, 24'd0});
        chk("R2 zero drive lane3", {24'b0, lg_data[3][31:24]}, 0);
        chk("R4 pattern2 after cr", nth_wr(A_PATTERN, 1), 2);
        chk("R10 pattern0 last", nth_wr(A_PATTERN, 2), 0);
        chk("R10 last op is pattern0", {lg_addr[n_log-1], lg_data[n_log-1][23:0]}, {A_PATTERN, 24'd0});
        chk("R11 final rate high", {24'b0, final_rate_o}, {24'b0, HIGH});
        @(negedge clk);
        chk("R11 done is one cycle", {31'b0, done_o}, 0);

        // R7 / R8 merge and clamp sweep, 2 lanes, inactive lanes request 0xF
        for (int n = 0; n < 16; n++) begin
            logic [7:0] b;
            b = exp_drv(4'(n));
            sink(2, 1, 0, 1'b0, 1'b0, 0, {8'hFF, 4'h1, 4'(n)});
            run(LOW, 3'd2, 8'h12, 1'b0, 2'd2, 8'h1B);
            chk("R7 R8 drive commit", nth_wr(A_DRIVE, 1), {16'h0, b, b});
            chk("R7 drive_level out", drive_level_o, {16'h0, b, b});
        end

        // R3 lane masking: 1 lane, upper lanes report nothing
        sink(1, 1, 0, 1'b0, 1'b0, 0, 16'h0);
        run(LOW, 3'd1, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R3 one-lane status decode trained", {31'b0, trained_o}, 1);
        chk("R3 one-lane status reads", cnt_ops(A_STATUS, 1'b0), 2);

        // R5 fixed request at swing 0: five reads then fail, no pattern 2
        sink(0, 1, 0, 1'b0, 1'b0, 0, 16'h0000);
        run(LOW, 3'd4, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R5 cr tries at one swing", cnt_ops(A_STATUS, 1'b0), 5);
        chk("R10 cr fail skips eq", cnt_ops(A_PATTERN, 1'b1), 2);
        chk("R11 cr fail flag", {31'b0, failed_o}, 1);

        // R5 swing change restarts count: 0 then 1 held -> 6 reads
        sink(0, 1, 0, 1'b0, 1'b0, 0, 16'h1111);
        run(LOW, 3'd4, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R5 restart on swing change", cnt_ops(A_STATUS, 1'b0), 6);

        // R6 rising ramp reaches max swing -> 4 reads
        sink(0, 1, 0, 1'b0, 1'b0, 1, 16'h0);
        run(LOW, 3'd4, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R6 stop at max swing", cnt_ops(A_STATUS, 1'b0), 4);
        chk("R6 last drive flagged", nth_wr(A_DRIVE, 3), {4{8'b0000_0111}});

        // R9 alignment missing: 6 eq reads, 5 adjusts
        sink(1, 1, 0, 1'b1, 1'b0, 0, 16'h0);
        run(LOW, 3'd4, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R9 eq try limit", cnt_ops(A_STATUS, 1'b0), 7);
        chk("R9 eq adjusts", cnt_ops(A_ADJUST, 1'b0), 5);
        chk("R9 no align fails", {31'b0, failed_o}, 1);

        // R9 eq passes on third read
        sink(1, 3, 0, 1'b0, 1'b0, 0, 16'h0);
        run(LOW, 3'd4, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R9 eq late pass reads", cnt_ops(A_STATUS, 1'b0), 4);
        chk("R9 eq late pass trained", {31'b0, trained_o}, 1);

        // R9 loss of clock recovery during eq
        sink(1, 0, 2, 1'b0, 1'b0, 0, 16'h0);
        run(LOW, 3'd4, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R9 cr loss stops eq", cnt_ops(A_STATUS, 1'b0), 3);
        chk("R9 cr loss fails", {31'b0, failed_o}, 1);

        // R11 fallback then pass
        sink(1, 1, 0, 1'b0, 1'b1, 0, 16'h0);
        run(HIGH, 3'd2, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R11 fallback rate writes", cnt_ops(A_RATE, 1'b1), 2);
        chk("R11 fallback second rate", nth_wr(A_RATE, 1), {24'b0, LOW});
        chk("R11 fallback trained", {30'b0, trained_o, failed_o}, 2);
        chk("R11 fallback final rate", {24'b0, final_rate_o}, {24'b0, LOW});
        chk("R10 pattern0 per attempt", nth_wr(A_PATTERN, 1), 0);

        // R11 fail at both rates: only one retry
        sink(0, 1, 0, 1'b0, 1'b0, 0, 16'h0);
        run(HIGH, 3'd4, 8'h12, 1'b0, 2'd3, 8'hFF);
        chk("R11 single retry", cnt_ops(A_RATE, 1'b1), 2);
        chk("R11 both fail reads", cnt_ops(A_STATUS, 1'b0), 10);
        chk("R11 both fail flags", {30'b0, trained_o, failed_o}, 1);

        // R11 start ignored while busy: a second pulse mid-run adds nothing
        sink(1, 1, 0, 1'b0, 1'b0, 0, 16'h0);
        @(negedge clk);
        rate_i = HIGH; lanes_i = 3'd4; n_log = 0; cur_pat = 0; st_cnt = 0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        rate_i = 8'h33; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk("R11 start ignored while busy", cnt_ops(A_RATE, 1'b1), 1);
        chk("R11 busy start rate kept", {24'b0, final_rate_o}, {24'b0, HIGH});

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule